// File: doc/BRIEF.md
# Wide-Memory Burst Read Data Path

This block sits between a 32-bit host bus and a memory whose data bus may be 32, 64 or 128 bits wide. It serves four-dword read bursts. A burst request captures the starting dword position. The memory then supplies the 128-bit line in one to four transfers, each marked by a valid strobe. Once the full line is held in an internal latch, the block waits a single cycle. It then hands the four dwords to the host on consecutive clocks, with a ready flag on each and a last flag on the fourth.

The latch is built from 16-bit slices, and two slices make up the 32-bit host word. With a 128-bit memory, a single memory access completes the whole burst. The host then sees the burst after one wait state, however fast the host clock runs. Narrower memories take more strobes to fill the same latch. A requester holds its request line high until the block takes it. Requests that arrive while a burst is still being filled or delivered wait until that burst has ended.

Top module: `bdp_burst_path`

## Requirements
- R1: After reset, host_rdy_o and host_last_o are 0 and host_data_o is all zeros.
- R2: With MEM_W=128, a single accepted memory strobe fills the latch. host_rdy_o stays 0 in the cycle after that strobe edge and is 1 for exactly four consecutive cycles after that.
- R3: Dwords are delivered in the order start XOR k for k = 0,1,2,3. Dword n of the line is memory bits [32n+31:32n]. So start 0 gives 0,1,2,3, start 1 gives 1,0,3,2, start 2 gives 2,3,0,1, and start 3 gives 3,2,1,0.
- R4: host_last_o is 1 only with the fourth ready dword of a burst, and host_rdy_o is 0 in the cycle after it.
- R5: host_data_o is all zeros whenever host_rdy_o is 0.
- R6: With MEM_W=64, the first accepted strobe loads dwords 0 (low 32 bits) and 1, and the second loads dwords 2 and 3. Delivery starts only after the second strobe, and idle cycles between strobes are allowed.
- R7: With MEM_W=32, four accepted strobes load dwords 0, 1, 2 and 3 in that order. Delivery starts only after the fourth strobe.
- R8: A memory strobe seen while no burst is filling has no effect. This covers strobes before a request and strobes during the wait cycle or the delivery cycles, and such strobes neither count toward a fill nor alter the data delivered.
- R9: A request that is high while a burst is in progress is not taken until the cycle after host_last_o. If it is still high then, it is taken at the next clock edge, with the start position present at that edge.
- R10: The start position is sampled only when a request is taken. Later changes on start_addr_i do not change the delivery order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_req_i | input | 1 | Burst request, held high until taken |
| start_addr_i | input | 2 | Starting dword position within the line |
| mem_data_i | input | MEM_W | Memory read data |
| mem_valid_i | input | 1 | Memory data valid strobe |
| host_data_o | output | 32 | Dword to the host, zero when not ready |
| host_rdy_o | output | 1 | Host dword valid this cycle |
| host_last_o | output | 1 | Fourth dword of the burst |

## Verification
The bench runs all four start positions on a 128-bit memory. A design that indexed the latch linearly, or used the wrong mapping from beat to dword, would deliver the dwords out of order. For the 64-bit and 32-bit widths it spreads the strobes apart with idle cycles, so a design that counted cycles rather than strobes would start delivery too early. It also fires stray strobes before a request and during delivery, which a design that always accepted strobes would either count toward a fill or let overwrite the line. A request held high across a whole burst, with its start position changed halfway through, shows whether the design restarts in the middle of a burst, drops the waiting request, or samples the start position late.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned HOST_W   = 32;
  localparam int unsigned SLICE_W  = 16;
  localparam int unsigned BURST_DW = 4;
  localparam int unsigned IDX_W    = $clog2(BURST_DW);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_XFER
  } bdp_state_e;

  // burst order: interleaved by XOR with the start position
  function automatic logic [IDX_W-1:0] burst_dw_sel(input logic [IDX_W-1:0] start,
                                                    input logic [IDX_W-1:0] idx);
    return start ^ idx;
  endfunction
endpackage

// File: rtl/bdp_ctrl.sv
module bdp_ctrl
  import bdp_pkg::*;
#(
  parameter int unsigned BEATS  = 1,
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  start_i,
  input  logic              mem_valid_i,
  output logic              fill_we_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              fill_done_o,
  output logic [IDX_W-1:0]  rd_sel_o,
  output logic              rdy_o,
  output logic              last_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BURST_DW - 1);

  bdp_state_e        st_q, st_d;
  logic [IDX_W-1:0]  start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept;

  assign accept      = (st_q == ST_IDLE) && req_i;
  assign fill_we_o   = (st_q == ST_FILL) && mem_valid_i;
  assign fill_done_o = fill_we_o && (beat_q == LAST_BEAT);
  assign beat_o      = beat_q;
  assign rdy_o       = (st_q == ST_XFER);
  assign last_o      = rdy_o && (idx_q == LAST_IDX);
  assign rd_sel_o    = burst_dw_sel(start_q, idx_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_FILL;
      ST_FILL: if (fill_done_o) st_d = ST_WAIT;
      ST_WAIT: st_d = ST_XFER;
      ST_XFER: if (idx_q == LAST_IDX) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      beat_q  <= '0;
      idx_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        start_q <= start_i;
        beat_q  <= '0;
      end else if (fill_we_o) begin
        beat_q <= beat_q + 1'b1;
      end
      if (st_q == ST_WAIT) idx_q <= '0;
      else if (rdy_o)      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bdp_slice.sv
module bdp_slice
  import bdp_pkg::*;
#(
  parameter int unsigned W     = SLICE_W,
  parameter int unsigned DEPTH = BURST_DW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         we_i,
  input  logic [DEPTH-1:0][W-1:0]  wdata_i,
  input  logic                     rd_en_i,
  input  logic [IDX_W-1:0]         rd_sel_i,
  output logic [W-1:0]             rd_data_o
);
  logic [DEPTH-1:0][W-1:0] lat_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lat_q[e] <= '0;
      else if (we_i[e]) lat_q[e] <= wdata_i[e];
    end
  end

  assign rd_data_o = rd_en_i ? lat_q[rd_sel_i] : '0;
endmodule

// File: rtl/bdp_burst_path.sv
module bdp_burst_path
  import bdp_pkg::*;
#(
  parameter int unsigned MEM_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_req_i,
  input  logic [1:0]        start_addr_i,
  input  logic [MEM_W-1:0]  mem_data_i,
  input  logic              mem_valid_i,
  output logic [HOST_W-1:0] host_data_o,
  output logic              host_rdy_o,
  output logic              host_last_o
);
  localparam int unsigned DW_PER_BEAT = MEM_W / HOST_W;
  localparam int unsigned BEATS       = BURST_DW / DW_PER_BEAT;
  localparam int unsigned BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned SLICES      = HOST_W / SLICE_W;

  logic                                   fill_we;
  logic                                   fill_done;
  logic [BEAT_W-1:0]                      beat;
  logic [IDX_W-1:0]                       rd_sel;
  logic [BURST_DW-1:0]                    dw_we;
  logic [BURST_DW-1:0][HOST_W-1:0]        dw_wdata;
  logic [SLICES-1:0][BURST_DW-1:0][SLICE_W-1:0] sl_wdata;

  bdp_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (burst_req_i),
    .start_i     (start_addr_i),
    .mem_valid_i (mem_valid_i),
    .fill_we_o   (fill_we),
    .beat_o      (beat),
    .fill_done_o (fill_done),
    .rd_sel_o    (rd_sel),
    .rdy_o       (host_rdy_o),
    .last_o      (host_last_o)
  );

  // dword d comes from lane (d mod lanes) of beat (d div lanes)
  for (genvar d = 0; d < BURST_DW; d++) begin : g_dw
    localparam int unsigned LANE = d % DW_PER_BEAT;
    localparam int unsigned GRP  = d / DW_PER_BEAT;
    assign dw_we[d]    = fill_we && (beat == BEAT_W'(GRP));
    assign dw_wdata[d] = mem_data_i[LANE*HOST_W +: HOST_W];
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    for (genvar d = 0; d < BURST_DW; d++) begin : g_wd
      assign sl_wdata[s][d] = dw_wdata[d][s*SLICE_W +: SLICE_W];
    end
    bdp_slice #(.W(SLICE_W), .DEPTH(BURST_DW)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (dw_we),
      .wdata_i   (sl_wdata[s]),
      .rd_en_i   (host_rdy_o),
      .rd_sel_i  (rd_sel),
      .rd_data_o (host_data_o[s*SLICE_W +: SLICE_W])
    );
  end
endmodule

// File: rtl/bdp_burst_chk.sv
module bdp_burst_chk #(
  parameter int unsigned HOST_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fill_done_i,
  input logic              host_rdy_o,
  input logic              host_last_o,
  input logic [HOST_W-1:0] host_data_o
);
  logic [2:0] rdy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdy_cnt_q <= '0;
    else if (host_last_o) rdy_cnt_q <= '0;
    else if (host_rdy_o)  rdy_cnt_q <= rdy_cnt_q + 1'b1;
  end

  assert_wait_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_i |=> !host_rdy_o);
  assert_first_dword_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_i |-> ##2 host_rdy_o);
  assert_contiguous_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdy_o && !host_last_o) |=> host_rdy_o);
  assert_last_with_rdy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_last_o |-> host_rdy_o);
  assert_last_is_fourth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_last_o |-> (rdy_cnt_q == 3'd3));
  assert_burst_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_last_o |=> !host_rdy_o);
  assert_zero_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rdy_o |-> (host_data_o == '0));
endmodule

bind bdp_burst_path bdp_burst_chk #(.HOST_W(32)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fill_done_i (fill_done),
  .host_rdy_o  (host_rdy_o),
  .host_last_o (host_last_o),
  .host_data_o (host_data_o)
);

// File: tb/bdp_burst_path_tb.sv
module bdp_burst_path_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]   req = '0;
  logic [2:0]   vld = '0;
  logic [1:0]   st_in [3];
  logic [127:0] md128 = '0;
  logic [63:0]  md64  = '0;
  logic [31:0]  md32  = '0;
  logic [31:0]  hd [3];
  logic [2:0]   rdy;
  logic [2:0]   last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bdp_burst_path #(.MEM_W(128)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_req_i(req[0]), .start_addr_i(st_in[0]),
    .mem_data_i(md128), .mem_valid_i(vld[0]),
    .host_data_o(hd[0]), .host_rdy_o(rdy[0]), .host_last_o(last[0]));
  bdp_burst_path #(.MEM_W(64)) u_dut64 (
    .clk_i(clk), .rst_ni(rst_n), .burst_req_i(req[1]), .start_addr_i(st_in[1]),
    .mem_data_i(md64), .mem_valid_i(vld[1]),
    .host_data_o(hd[1]), .host_rdy_o(rdy[1]), .host_last_o(last[1]));
  bdp_burst_path #(.MEM_W(32)) u_dut32 (
    .clk_i(clk), .rst_ni(rst_n), .burst_req_i(req[2]), .start_addr_i(st_in[2]),
    .mem_data_i(md32), .mem_valid_i(vld[2]),
    .host_data_o(hd[2]), .host_rdy_o(rdy[2]), .host_last_o(last[2]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input logic [7:0] seed);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = {8'hC0, seed, 8'h5A, 8'(i)};
    return l;
  endfunction

  task automatic drive_beat(input int k, input int b, input logic [127:0] line);
    case (k)
      0: md128 = line;
      1: md64  = line[b*64 +: 64];
      default: md32 = line[b*32 +: 32];
    endcase
  endtask

  // one full burst on dut k; gaps puts idle cycles before strobes,
  // junk strobes other data during delivery
  task automatic run_burst(input int k, input logic [1:0] st, input logic [127:0] line,
                           input bit gaps, input bit junk, input string tag);
    int nb = (k == 0) ? 1 : (k == 1) ? 2 : 4;
    @(negedge clk); req[k] = 1'b1; st_in[k] = st;
    @(negedge clk); req[k] = 1'b0; st_in[k] = ~st; // R10: late change ignored
    for (int b = 0; b < nb; b++) begin
      if (gaps) begin
        @(negedge clk);
        chk({tag, " gap rdy"}, 32'(rdy[k]), 32'd0);
      end
      vld[k] = 1'b1; drive_beat(k, b, line);
      @(negedge clk); vld[k] = 1'b0;
      chk({tag, " fill/wait rdy (R2)"}, 32'(rdy[k]), 32'd0);
      chk({tag, " idle data zero (R5)"}, hd[k], 32'd0);
    end
    if (junk) begin
      vld[k] = 1'b1; drive_beat(k, 0, ~line);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({tag, " rdy (R2)"}, 32'(rdy[k]), 32'd1);
      chk({tag, " dword order (R3)"}, hd[k], line[(2'(st) ^ 2'(i))*32 +: 32]);
      chk({tag, " last flag (R4)"}, 32'(last[k]), 32'(i == 3));
    end
    vld[k] = 1'b0;
    @(negedge clk);
    chk({tag, " rdy after last (R4)"}, 32'(rdy[k]), 32'd0);
    chk({tag, " data after last (R5)"}, hd[k], 32'd0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      chk("R1 rdy at reset", 32'(rdy[k]), 32'd0);
      chk("R1 last at reset", 32'(last[k]), 32'd0);
      chk("R1 data at reset", hd[k], 32'd0);
    end
  endtask

  task automatic t_order128();
    for (int s = 0; s < 4; s++)
      run_burst(0, 2'(s), mk_line(8'(16 + s)), 1'b0, 1'b0, "R2 R3 w128");
  endtask

  task automatic t_width64();
    run_burst(1, 2'd1, mk_line(8'h40), 1'b1, 1'b0, "R6 w64");
    run_burst(1, 2'd3, mk_line(8'h41), 1'b0, 1'b0, "R6 w64");
  endtask

  task automatic t_width32();
    run_burst(2, 2'd3, mk_line(8'h50), 1'b1, 1'b0, "R7 w32");
    run_burst(2, 2'd2, mk_line(8'h51), 1'b0, 1'b0, "R7 w32");
  endtask

  task automatic t_ignore();
    // R8: stray strobes while idle must not count toward the fill
    @(negedge clk); vld[1] = 1'b1; md64 = 64'hDEAD_BEEF_DEAD_BEEF;
    @(negedge clk); vld[2] = 1'b1; md32 = 32'hBAD0_BAD0;
    @(negedge clk); vld[1] = 1'b0; vld[2] = 1'b0;
    chk("R8 no rdy from idle strobe", 32'(rdy[1] | rdy[2]), 32'd0);
    run_burst(1, 2'd2, mk_line(8'h60), 1'b0, 1'b1, "R8 w64");
    run_burst(2, 2'd1, mk_line(8'h61), 1'b0, 1'b1, "R8 w32");
    run_burst(0, 2'd0, mk_line(8'h62), 1'b0, 1'b1, "R8 w128");
  endtask

  task automatic t_holdoff();
    logic [127:0] la = mk_line(8'h70);
    logic [127:0] lb = mk_line(8'h71);
    @(negedge clk); req[0] = 1'b1; st_in[0] = 2'd1;
    @(negedge clk); vld[0] = 1'b1; md128 = la;
    @(negedge clk); vld[0] = 1'b0;
    chk("R9 wait state", 32'(rdy[0]), 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 1) st_in[0] = 2'd2;
      chk("R9 held req no restart rdy", 32'(rdy[0]), 32'd1);
      chk("R9 held req no restart data", hd[0], la[(2'd1 ^ 2'(i))*32 +: 32]);
    end
    @(negedge clk);
    chk("R9 idle after last", 32'(rdy[0]), 32'd0);
    @(negedge clk); req[0] = 1'b0; vld[0] = 1'b1; md128 = lb;
    @(negedge clk); vld[0] = 1'b0;
    chk("R9 second burst wait", 32'(rdy[0]), 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 second burst rdy", 32'(rdy[0]), 32'd1);
      chk("R9 second burst start", hd[0], lb[(2'd2 ^ 2'(i))*32 +: 32]);
    end
    @(negedge clk);
    chk("R9 end of second burst", 32'(rdy[0]), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) st_in[k] = 2'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_order128();
    t_width64();
    t_width32();
    t_ignore();
    t_holdoff();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule